// File: doc/BRIEF.md
# Prioritized Transmit Slot Scheduler

This block arbitrates among three outgoing message slots of a CAN controller. Each slot keeps a pending bit, a 2-bit priority and four status flags: done, lost arbitration, error and aborted. When the bus is free, the scheduler picks one pending slot and hands its index to the protocol engine through a one-cycle start strobe. It then waits for the engine's result and updates the slot's flags. Message payloads and bit-level framing live elsewhere. The engine is seen only through the start strobe and a done strobe with a 2-bit result code.

A request reaches a slot in one of two ways. The host can write a slot, which loads the priority and sets or clears the pending bit. Or an active-low request pin can fall while its pin enable is set. The pin enables can only be written while configuration mode is asserted. A level-sensitive abort-all input cancels the queued work. A one-shot mode input limits each slot to a single attempt.

The controller has three states. S_IDLE moves to S_LAUNCH when a slot is pending, the bus is idle, abort-all is low and configuration mode is off; this transition is the launch decision. S_LAUNCH always moves to S_FLIGHT after one cycle. S_FLIGHT returns to S_IDLE when the engine reports a result; this transition is the resolve step. In every other case the state holds.

Top module: `txq_sched`

## Requirements
- R1: After reset every pending bit, priority, flag, pin enable and the interrupt output are 0, and no start is issued.
- R2: Among pending slots, the one with the largest priority value is launched. Priority 3 is the highest and 0 the lowest.
- R3: When pending slots share the top priority, the one with the higher slot index is launched first.
- R4: A launch happens only from S_IDLE, with bus_idle high, abort_all low and cfg_mode low. eng_start is high for exactly one cycle, with eng_slot holding the slot. Only one slot is in flight, and no new choice is made until eng_done arrives.
- R5: Setting a slot's pending bit, by host write or by pin, clears that slot's lost, error and aborted flags.
- R6: Result code 00 (success) clears the pending bit and sets the slot's done flag. irq is high while any done flag is set and its done_ie bit is set. A done_clr bit clears its done flag.
- R7: Result code 01 (lost arbitration) keeps the pending bit, sets the lost flag, and the slot is launched again later.
- R8: Result code 10 (error) keeps the pending bit, sets the slot's error flag and the shared message-error flag. irq is high while the message-error flag and merr_ie are both set. merr_clr clears the message-error flag.
- R9: With oneshot high, the pending bit is cleared after any result, whatever the code.
- R10: A host write with host_req low clears that slot's pending bit and leaves its aborted flag unchanged.
- R11: While abort_all is high, every pending slot that is not in flight has its pending bit cleared and its aborted flag set, and no launch occurs. A slot already in flight runs to its result. If that result is a failure, its pending bit is cleared and its aborted flag is set. If it succeeds, it completes normally.
- R12: A falling edge on rts_n[i] sets slot i's pending bit if pin enable i is set. The pin passes through two synchronizer flops, so the bit is visible after the third rising clock edge that follows the pin change. A pin held low sets the bit only once.
- R13: The pin enables change only on a pin_cfg_we cycle with cfg_mode high. Writes made outside configuration mode are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host slot write strobe |
| host_slot | input | IDX_W | Slot addressed by the write |
| host_req | input | 1 | Written pending value (1 set, 0 clear) |
| host_prio | input | PRIO_W | Written priority |
| cfg_mode | input | 1 | Configuration mode; gates pin-enable writes and launches |
| pin_cfg_we | input | 1 | Pin-enable write strobe |
| pin_cfg_val | input | NSLOT | New pin enables |
| rts_n | input | NSLOT | Active-low request pins, asynchronous |
| oneshot | input | 1 | Single-attempt mode |
| abort_all | input | 1 | Global abort level |
| done_ie | input | NSLOT | Per-slot done interrupt enables |
| merr_ie | input | 1 | Message-error interrupt enable |
| done_clr | input | NSLOT | Clear strobes for the done flags |
| merr_clr | input | 1 | Clear strobe for the message-error flag |
| bus_idle | input | 1 | Engine reports the bus is free |
| eng_done | input | 1 | Engine result strobe |
| eng_res | input | 2 | Result: 00 success, 01 lost, 10 error |
| eng_start | output | 1 | One-cycle launch strobe |
| eng_slot | output | IDX_W | Slot being launched or in flight |
| req_o | output | NSLOT | Pending bits |
| done_o | output | NSLOT | Done flags |
| lost_o | output | NSLOT | Lost-arbitration flags |
| err_o | output | NSLOT | Error flags |
| abt_o | output | NSLOT | Aborted flags |
| merr_o | output | 1 | Shared message-error flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the engine never raises eng_done except in S_FLIGHT. They also assume that a host write and a pin edge never hit the same slot in the cycle its result lands, and that host_slot always names an existing slot. The stimulus keeps to these rules. It answers only after the start strobe has been seen and one more cycle has passed. It holds bus_idle low whenever it changes requests around a result. It addresses only slots 0 to 2. Every expected launch order is queued before bus_idle is raised, so a start the scoreboard does not expect is reported as a failure.

// File: rtl/txq_pkg.sv
package txq_pkg;
    typedef enum logic [1:0] {
        RES_OK   = 2'b00,
        RES_LOST = 2'b01,
        RES_ERR  = 2'b10
    } txq_res_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'b00,
        S_LAUNCH = 2'b01,
        S_FLIGHT = 2'b10
    } txq_state_e;
endpackage

// File: rtl/txq_pin_edge.sv
module txq_pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    logic [STAGES:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '1;
        else        sr_q <= {sr_q[STAGES-1:0], pin_n};
    end

    assign fall = sr_q[STAGES] & ~sr_q[STAGES-1];

    // R12
    fall_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/txq_pick.sv
module txq_pick #(
    parameter int NSLOT  = 3,
    parameter int PRIO_W = 2,
    localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NSLOT-1:0]              pend,
    input  logic [NSLOT-1:0][PRIO_W-1:0]  prio,
    output logic                          valid,
    output logic [IDX_W-1:0]              sel
);
    logic [PRIO_W-1:0] best;

    always_comb begin
        valid = 1'b0;
        sel   = '0;
        best  = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (pend[i] && (!valid || prio[i] >= best)) begin
                valid = 1'b1;
                sel   = IDX_W'(i);
                best  = prio[i];
            end
        end
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_chk
        // R2
        pick_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (valid && pend[g]) |-> (prio[g] <= prio[sel]));
        // R3
        pick_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (valid && pend[g] && prio[g] == prio[sel]) |-> (IDX_W'(g) <= sel));
    end
endmodule

// File: rtl/txq_slot.sv
module txq_slot
    import txq_pkg::*;
#(
    parameter int PRIO_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_req,
    input  logic [PRIO_W-1:0] wr_prio,
    input  logic              pin_set,
    input  logic              kill,
    input  logic              res_vld,
    input  logic [1:0]        res,
    input  logic              oneshot,
    input  logic              abort_all,
    input  logic              done_clr,
    output logic              req_q,
    output logic [PRIO_W-1:0] prio_q,
    output logic              done_q,
    output logic              lost_q,
    output logic              err_q,
    output logic              abt_q
);
    logic set_any;
    logic fail;

    assign set_any = (wr_en && wr_req) || pin_set;
    assign fail    = res_vld && (res != RES_OK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            prio_q <= '0;
            done_q <= 1'b0;
            lost_q <= 1'b0;
            err_q  <= 1'b0;
            abt_q  <= 1'b0;
        end else begin
            if (done_clr) done_q <= 1'b0;
            if (res_vld) begin
                if (res == RES_OK) begin
                    req_q  <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    if (res == RES_LOST) lost_q <= 1'b1;
                    else                 err_q  <= 1'b1;
                    if (oneshot || abort_all) req_q <= 1'b0;
                    if (abort_all)            abt_q <= 1'b1;
                end
            end
            if (kill && req_q) begin
                req_q <= 1'b0;
                abt_q <= 1'b1;
            end
            if (wr_en) begin
                prio_q <= wr_prio;
                if (!wr_req) req_q <= 1'b0;
            end
            if (set_any) begin
                req_q  <= 1'b1;
                lost_q <= 1'b0;
                err_q  <= 1'b0;
                abt_q  <= 1'b0;
            end
        end
    end

    // R6
    ok_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res == RES_OK && !set_any) |=> (!req_q && done_q));
    // R5
    set_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_any |=> (req_q && !lost_q && !err_q && !abt_q));
    // R10
    hclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_req && !pin_set && !kill && !res_vld) |=> (!req_q && $stable(abt_q)));
    // R9
    oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && oneshot && !set_any) |=> !req_q);
    // R11
    abort_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && abort_all && !set_any) |=> (!req_q && abt_q));
endmodule

// File: rtl/txq_sched.sv
module txq_sched
    import txq_pkg::*;
#(
    parameter int NSLOT    = 3,
    parameter int PRIO_W   = 2,
    parameter int SYNC_STG = 2,
    localparam int IDX_W   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [IDX_W-1:0]  host_slot,
    input  logic              host_req,
    input  logic [PRIO_W-1:0] host_prio,
    input  logic              cfg_mode,
    input  logic              pin_cfg_we,
    input  logic [NSLOT-1:0]  pin_cfg_val,
    input  logic [NSLOT-1:0]  rts_n,
    input  logic              oneshot,
    input  logic              abort_all,
    input  logic [NSLOT-1:0]  done_ie,
    input  logic              merr_ie,
    input  logic [NSLOT-1:0]  done_clr,
    input  logic              merr_clr,
    input  logic              bus_idle,
    input  logic              eng_done,
    input  logic [1:0]        eng_res,
    output logic              eng_start,
    output logic [IDX_W-1:0]  eng_slot,
    output logic [NSLOT-1:0]  req_o,
    output logic [NSLOT-1:0]  done_o,
    output logic [NSLOT-1:0]  lost_o,
    output logic [NSLOT-1:0]  err_o,
    output logic [NSLOT-1:0]  abt_o,
    output logic              merr_o,
    output logic              irq
);
    txq_state_e state_q, state_d;
    logic [IDX_W-1:0]              cur_q;
    logic [NSLOT-1:0]              pin_en_q;
    logic                          merr_q;
    logic [NSLOT-1:0][PRIO_W-1:0]  prio_w;
    logic [NSLOT-1:0]              fall_w;
    logic [NSLOT-1:0]              res_vld_w;
    logic [NSLOT-1:0]              kill_w;
    logic                          pick_valid;
    logic [IDX_W-1:0]              pick_sel;
    logic                          go;
    logic                          resolve;

    // Request pin synchronizers and edge detectors
    for (genvar g = 0; g < NSLOT; g++) begin : g_pin
        txq_pin_edge #(.STAGES(SYNC_STG)) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_n (rts_n[g]),
            .fall  (fall_w[g])
        );
    end

    // Per-slot state
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic wr_hit;
        assign wr_hit = host_wr && (host_slot == IDX_W'(g));
        txq_slot #(.PRIO_W(PRIO_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_hit),
            .wr_req    (host_req),
            .wr_prio   (host_prio),
            .pin_set   (fall_w[g] && pin_en_q[g]),
            .kill      (kill_w[g]),
            .res_vld   (res_vld_w[g]),
            .res       (eng_res),
            .oneshot   (oneshot),
            .abort_all (abort_all),
            .done_clr  (done_clr[g]),
            .req_q     (req_o[g]),
            .prio_q    (prio_w[g]),
            .done_q    (done_o[g]),
            .lost_q    (lost_o[g]),
            .err_q     (err_o[g]),
            .abt_q     (abt_o[g])
        );
    end

    txq_pick #(.NSLOT(NSLOT), .PRIO_W(PRIO_W)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (req_o),
        .prio  (prio_w),
        .valid (pick_valid),
        .sel   (pick_sel)
    );

    assign go      = pick_valid && bus_idle && !abort_all && !cfg_mode;
    assign resolve = (state_q == S_FLIGHT) && eng_done;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (go) state_d = S_LAUNCH;
            S_LAUNCH: state_d = S_FLIGHT;
            S_FLIGHT: if (eng_done) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register and launch latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && go) cur_q <= pick_sel;
        end
    end

    // Configuration and shared flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_en_q <= '0;
            merr_q   <= 1'b0;
        end else begin
            if (cfg_mode && pin_cfg_we) pin_en_q <= pin_cfg_val;
            if (merr_clr) merr_q <= 1'b0;
            if (resolve && eng_res == RES_ERR) merr_q <= 1'b1;
        end
    end

    // Outputs and per-slot strobes
    always_comb begin
        eng_start = (state_q == S_LAUNCH);
        eng_slot  = cur_q;
        for (int i = 0; i < NSLOT; i++) begin
            res_vld_w[i] = resolve && (cur_q == IDX_W'(i));
            kill_w[i]    = abort_all && !((state_q != S_IDLE) && (cur_q == IDX_W'(i)));
        end
        merr_o = merr_q;
        irq    = (|(done_o & done_ie)) || (merr_q && merr_ie);
    end

    // R4
    launch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> (!eng_start && state_q == S_FLIGHT));
    // R4
    flight_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FLIGHT && !eng_done) |=> ($stable(eng_slot) && !eng_start));
    // R11
    no_launch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_all || cfg_mode || !bus_idle) |=> !eng_start);
    // R13
    pin_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |=> $stable(pin_en_q));
    // R8
    merr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve && eng_res == RES_ERR) |=> merr_o);
endmodule

// File: tb/sim_txq_sched.sv
`timescale 1ns/1ps
module sim_txq_sched;
    localparam int NSLOT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr = 0, host_req = 0;
    logic [1:0] host_slot = '0, host_prio = '0;
    logic cfg_mode = 0, pin_cfg_we = 0;
    logic [NSLOT-1:0] pin_cfg_val = '0, rts_n = '1;
    logic oneshot = 0, abort_all = 0;
    logic [NSLOT-1:0] done_ie = '0, done_clr = '0;
    logic merr_ie = 0, merr_clr = 0, bus_idle = 0, eng_done = 0;
    logic [1:0] eng_res = '0;
    logic eng_start;
    logic [1:0] eng_slot;
    logic [NSLOT-1:0] req_o, done_o, lost_o, err_o, abt_o;
    logic merr_o, irq;

    int n_run = 0;
    int n_fail = 0;
    int exp_q[$];

    always #2.5 clk = ~clk;

    txq_sched u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_slot(host_slot),
        .host_req(host_req), .host_prio(host_prio), .cfg_mode(cfg_mode),
        .pin_cfg_we(pin_cfg_we), .pin_cfg_val(pin_cfg_val), .rts_n(rts_n),
        .oneshot(oneshot), .abort_all(abort_all), .done_ie(done_ie),
        .merr_ie(merr_ie), .done_clr(done_clr), .merr_clr(merr_clr),
        .bus_idle(bus_idle), .eng_done(eng_done), .eng_res(eng_res),
        .eng_start(eng_start), .eng_slot(eng_slot), .req_o(req_o),
        .done_o(done_o), .lost_o(lost_o), .err_o(err_o), .abt_o(abt_o),
        .merr_o(merr_o), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: every launch must match the next queued slot (R2 R3 R4)
    always @(negedge clk) begin
        if (rst_n && eng_start) begin
            if (exp_q.size() == 0) begin
                chk("R4 unexpected launch", {30'd0, eng_slot}, 32'hFF);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk("R2/R3 launch order", {30'd0, eng_slot}, e);
            end
        end
    end

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic host_write(input int slot, input logic rq, input int pr);
        @(negedge clk);
        host_wr = 1; host_slot = 2'(slot); host_req = rq; host_prio = 2'(pr);
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic wait_launch();
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (eng_start) return;
        end
        chk("R4 launch timeout", 0, 1);
    endtask

    task automatic respond(input logic [1:0] code);
        @(negedge clk);
        eng_done = 1; eng_res = code;
        @(negedge clk);
        eng_done = 0;
    endtask

    task automatic pulse_done_clr();
        @(negedge clk); done_clr = '1;
        @(negedge clk); done_clr = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk("R4 watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        cyc(4);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 req", req_o, 0);
        chk("R1 flags", {done_o, lost_o, err_o, abt_o, merr_o}, 0);
        chk("R1 start/irq", {eng_start, irq}, 0);

        // R2 priority order, R6 success
        done_ie = '1;
        host_write(0, 1, 3);
        host_write(1, 1, 1);
        host_write(2, 1, 2);
        chk("R5 requests set", req_o, 3'b111);
        exp_q.push_back(0); exp_q.push_back(2); exp_q.push_back(1);
        bus_idle = 1;
        for (int k = 0; k < 3; k++) begin
            wait_launch();
            respond(2'b00);
        end
        bus_idle = 0;
        chk("R6 req cleared", req_o, 0);
        chk("R6 done set", done_o, 3'b111);
        chk("R6 irq on done", irq, 1);
        pulse_done_clr();
        chk("R6 done cleared", {done_o, irq}, 0);

        // R3 tie toward higher index
        host_write(0, 1, 2);
        host_write(1, 1, 2);
        exp_q.push_back(1); exp_q.push_back(0);
        bus_idle = 1;
        wait_launch(); respond(2'b00);
        wait_launch(); respond(2'b00);
        bus_idle = 0;
        chk("R3 both done", done_o, 3'b011);
        pulse_done_clr();

        // R7 lost arbitration then retry; R8 error
        merr_ie = 1; done_ie = '0;
        host_write(2, 1, 0);
        exp_q.push_back(2); exp_q.push_back(2);
        bus_idle = 1;
        wait_launch(); respond(2'b01);
        chk("R7 req kept", req_o[2], 1);
        chk("R7 lost flag", lost_o[2], 1);
        wait_launch(); respond(2'b10);
        bus_idle = 0;
        chk("R8 req kept", req_o[2], 1);
        chk("R8 err flag", err_o[2], 1);
        chk("R8 merr and irq", {merr_o, irq}, 2'b11);
        host_write(2, 1, 0);
        chk("R5 flags cleared on set", {lost_o[2], err_o[2], abt_o[2]}, 0);
        @(negedge clk); merr_clr = 1;
        @(negedge clk); merr_clr = 0;
        chk("R8 merr cleared", {merr_o, irq}, 0);
        exp_q.push_back(2);
        bus_idle = 1;
        wait_launch(); respond(2'b00);
        bus_idle = 0;
        chk("R6 retry success", {req_o[2], done_o[2]}, 2'b01);
        pulse_done_clr();

        // R9 one-shot
        oneshot = 1;
        host_write(1, 1, 3);
        exp_q.push_back(1);
        bus_idle = 1;
        wait_launch(); respond(2'b01);
        bus_idle = 0;
        chk("R9 req dropped", req_o[1], 0);
        chk("R9 lost flag", lost_o[1], 1);
        bus_idle = 1; cyc(5); bus_idle = 0;
        chk("R9 no second attempt", req_o, 0);
        oneshot = 0;

        // R10 per-slot abort
        host_write(0, 1, 1);
        host_write(0, 0, 1);
        chk("R10 req cleared", req_o[0], 0);
        chk("R10 no abort flag", abt_o[0], 0);
        bus_idle = 1; cyc(3); bus_idle = 0;

        // R11 abort-all on queued slots
        host_write(0, 1, 1);
        host_write(2, 1, 3);
        @(negedge clk); abort_all = 1;
        @(negedge clk);
        chk("R11 queued cancelled", req_o, 0);
        chk("R11 abort flags", abt_o, 3'b101);
        bus_idle = 1; cyc(4); bus_idle = 0;
        abort_all = 0;
        host_write(0, 1, 1);
        chk("R5 abort flag cleared", abt_o[0], 0);
        exp_q.push_back(0);
        bus_idle = 1;
        wait_launch(); respond(2'b00);
        bus_idle = 0;
        pulse_done_clr();

        // R11 abort-all while in flight, failing
        host_write(2, 1, 3);
        host_write(1, 1, 0);
        exp_q.push_back(2);
        bus_idle = 1;
        wait_launch();
        bus_idle = 0; abort_all = 1;
        respond(2'b10);
        chk("R11 inflight fail aborted", {req_o[2], abt_o[2], err_o[2]}, 3'b011);
        chk("R11 other slot aborted", {req_o[1], abt_o[1]}, 2'b01);
        abort_all = 0;
        @(negedge clk); merr_clr = 1;
        @(negedge clk); merr_clr = 0;

        // R11 abort-all while in flight, succeeding
        host_write(0, 1, 3);
        exp_q.push_back(0);
        bus_idle = 1;
        wait_launch();
        bus_idle = 0; abort_all = 1;
        respond(2'b00);
        chk("R11 inflight success", {req_o[0], done_o[0], abt_o[0]}, 3'b010);
        abort_all = 0;
        pulse_done_clr();

        // R13 pin config ignored outside configuration mode
        @(negedge clk); pin_cfg_we = 1; pin_cfg_val = '1;
        @(negedge clk); pin_cfg_we = 0;
        rts_n[1] = 0; cyc(4);
        chk("R13 write ignored", req_o[1], 0);
        rts_n[1] = 1; cyc(3);
        @(negedge clk); cfg_mode = 1; pin_cfg_we = 1; pin_cfg_val = 3'b010;
        @(negedge clk); cfg_mode = 0; pin_cfg_we = 0;

        // R12 synchronized falling edge
        rts_n[1] = 0;
        cyc(2);
        chk("R12 not yet", req_o[1], 0);
        cyc(1);
        chk("R12 req set", req_o[1], 1);
        host_write(1, 0, 0);
        cyc(3);
        chk("R12 held low no retrigger", req_o[1], 0);
        rts_n[1] = 1;
        rts_n[0] = 0; cyc(4);
        chk("R12 disabled pin ignored", req_o[0], 0);
        rts_n[0] = 1; cyc(3);
        chk("R4 scoreboard drained", exp_q.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule